// File: doc/BRIEF.md
# Delayed Write Queue Controller

This block sits between the two bus interfaces of a bridge and carries single-word writes across by the delayed method. An initiator's first attempt is always answered with a retry. While the initiator is being told to retry, the block captures the write's address, bus command, data word and byte enables into a small queue. A master port on the far side then replays the queued writes one at a time. Each replay is exactly one 32-bit data phase. The block stores how each replay ended.

When the initiator comes back with the same address and command, the block answers in the same cycle with the stored outcome and frees the entry. A normal completion is answered with ready. A target or master abort is answered with target abort, and the parity flag is passed on. The far side may keep answering with retries. After 2^RETRY_W of them in a row, the replay is abandoned, an optional system-error pulse is raised, and the waiting initiator later receives a target abort. A control input switches this limit off.

Top module: `dwq_ctrl`

## Requirements
- R1: A write attempt that matches no stored entry is answered with retry only (ready, target abort and parity flag low), in the same cycle.
- R2: A new entry is stored only when a slot is free and no stored entry has the same address and command; an unmatched attempt that finds the queue full gets a retry and stores nothing.
- R3: Matching compares address and command only, and ignores byte enables; an attempt that matches an entry not yet completed gets a retry and leaves the stored data and byte enables unchanged.
- R4: The far-side port presents one entry at a time, in the order the entries were stored. It shows that entry's address, command, data and byte enables, and holds them steady until the transfer ends.
- R5: A matching attempt after completion is answered in the same cycle and frees the entry. The answer is ready for a normal completion, or target abort for a target abort, master abort or discard. The parity flag is set if a parity error was seen at any cycle of that transfer.
- R6: With the limit enabled, the 2^RETRY_W-th consecutive far-side retry ends the transfer as a discard, and the next entry is presented from the following cycle.
- R7: `serr` pulses high for one cycle, in the cycle after a discard, when `serr_en` was high at the discard; it is low otherwise.
- R8: With `retry_lim_en` low, far-side retries never end a transfer.
- R9: The retry count starts from zero for every transfer and clears when the far side completes or aborts; idle cycles do not clear it.
- R10: After reset no entry is stored, `tg_valid` and `serr` are low, and all initiator response outputs are low.
- R11: Exactly one of retry, ready or target abort is high in a cycle with `in_req`, and none when `in_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retry_lim_en | input | 1 | Enables the consecutive-retry limit |
| serr_en | input | 1 | Enables the system-error pulse on discard |
| in_req | input | 1 | Initiator write attempt this cycle |
| in_addr | input | ADDR_W | Attempt address |
| in_cmd | input | CMD_W | Attempt bus command |
| in_data | input | DATA_W | Attempt write data |
| in_be | input | DATA_W/8 | Attempt byte enables |
| in_rsp_retry | output | 1 | Answer: retry |
| in_rsp_ready | output | 1 | Answer: completed normally |
| in_rsp_tabort | output | 1 | Answer: target abort |
| in_rsp_perr | output | 1 | Parity error was seen on the replay |
| tg_valid | output | 1 | Far-side transfer requested |
| tg_addr | output | ADDR_W | Far-side address |
| tg_cmd | output | CMD_W | Far-side bus command |
| tg_data | output | DATA_W | Far-side data word |
| tg_be | output | DATA_W/8 | Far-side byte enables |
| tg_trdy | input | 1 | Far side accepted the data phase |
| tg_tabort | input | 1 | Far side signalled target abort |
| tg_mabort | input | 1 | Transfer ended by master abort |
| tg_retry | input | 1 | Far side signalled retry |
| tg_perr | input | 1 | Parity error seen this cycle |
| serr | output | 1 | System-error pulse after a discard |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-hot initiator answer, the rule that at most one entry matches a key, the queue never overflowing or underflowing, the presented entry holding steady until its transfer ends, the idle retry counter being zero, and the error pulse following a discard. Other behaviour depends on the history of the traffic, so only the bench scenarios can show it. This covers the stored outcome reported on a later attempt, the issue order, the byte enables being ignored, the discard landing exactly at the limit, and the limit staying quiet when disabled or after a counter reset.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
   typedef enum logic [1:0] {
      TERM_OK      = 2'd0,
      TERM_TABORT  = 2'd1,
      TERM_MABORT  = 2'd2,
      TERM_DISCARD = 2'd3
   } term_e;

   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_PEND = 2'd1,
      SLOT_DONE = 2'd2
   } slot_e;
endpackage

// File: rtl/dwq_match.sv
module dwq_match #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 32,
   parameter int CMD_W  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [DEPTH-1:0]              used,
   input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
   input  logic [DEPTH-1:0][CMD_W-1:0]   ent_cmd,
   input  logic [ADDR_W-1:0]             key_addr,
   input  logic [CMD_W-1:0]              key_cmd,
   output logic [DEPTH-1:0]              hit
);
   // byte enables deliberately absent from the key (R3)
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = used[g] && (ent_addr[g] == key_addr) && (ent_cmd[g] == key_cmd);
   end

   a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit))
      else $error("more than one entry holds the same key");
endmodule

// File: rtl/dwq_order_fifo.sv
module dwq_order_fifo #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [IDX_W-1:0] push_idx,
   input  logic             pop,
   output logic [IDX_W-1:0] head_idx,
   output logic             empty
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [DEPTH-1:0][IDX_W-1:0] ring;
   logic [IDX_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CNT_W-1:0] cnt;
   logic             full;

   if ((1 << IDX_W) == DEPTH) begin : g_pow2
      assign rd_nxt = rd_ptr + 1'b1;
      assign wr_nxt = wr_ptr + 1'b1;
   end else begin : g_wrap
      assign rd_nxt = (rd_ptr == IDX_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      assign wr_nxt = (wr_ptr == IDX_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
   end

   assign empty    = (cnt == '0);
   assign full     = (cnt == CNT_W'(DEPTH));
   assign head_idx = ring[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring   <= '0;
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) begin
            ring[wr_ptr] <= push_idx;
            wr_ptr       <= wr_nxt;
         end
         if (pop) rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full)
      else $error("issue order ring overflow");
   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty)
      else $error("issue order ring underflow");
endmodule

// File: rtl/dwq_retry_timer.sv
module dwq_retry_timer #(
   parameter int CNT_W = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic retry,
   input  logic term,
   input  logic lim_en,
   output logic expire
);
   logic [CNT_W-1:0] cnt;

   assign expire = active && retry && !term && lim_en && (cnt == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (!active || term || expire) cnt <= '0;
      else if (retry && lim_en)           cnt <= cnt + 1'b1;
   end

   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n) !active |-> (cnt == '0))
      else $error("retry count not zero between transfers");
endmodule

// File: rtl/dwq_ctrl.sv
module dwq_ctrl
   import dwq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CMD_W   = 4,
   parameter int DEPTH   = 4,
   parameter int RETRY_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                retry_lim_en,
   input  logic                serr_en,
   input  logic                in_req,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic [CMD_W-1:0]    in_cmd,
   input  logic [DATA_W-1:0]   in_data,
   input  logic [DATA_W/8-1:0] in_be,
   output logic                in_rsp_retry,
   output logic                in_rsp_ready,
   output logic                in_rsp_tabort,
   output logic                in_rsp_perr,
   output logic                tg_valid,
   output logic [ADDR_W-1:0]   tg_addr,
   output logic [CMD_W-1:0]    tg_cmd,
   output logic [DATA_W-1:0]   tg_data,
   output logic [DATA_W/8-1:0] tg_be,
   input  logic                tg_trdy,
   input  logic                tg_tabort,
   input  logic                tg_mabort,
   input  logic                tg_retry,
   input  logic                tg_perr,
   output logic                serr
);
   localparam int BE_W  = DATA_W / 8;
   localparam int IDX_W = $clog2(DEPTH);

   if (DATA_W != 32) begin : g_bad_width
      $error("far-side transfer is a single 32-bit data phase; DATA_W must be 32");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (RETRY_W < 1) begin : g_bad_retry
      $error("RETRY_W must be at least 1");
   end

   slot_e                      slot_st   [DEPTH];
   term_e                      slot_term [DEPTH];
   logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
   logic [DEPTH-1:0][CMD_W-1:0]  slot_cmd;
   logic [DEPTH-1:0][DATA_W-1:0] slot_data;
   logic [DEPTH-1:0][BE_W-1:0]   slot_be;
   logic [DEPTH-1:0]             slot_perr;
   logic [DEPTH-1:0]             slot_used, slot_hit;

   logic             hit_any, hit_done, free_any, enq, release_e;
   logic [IDX_W-1:0] hit_idx, free_idx, head_idx;
   logic             ord_empty, tg_term, discard, tg_end, perr_acc;
   term_e            end_code;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) slot_used[i] = (slot_st[i] != SLOT_FREE);
   end

   dwq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_match (
      .clk(clk), .rst_n(rst_n), .used(slot_used), .ent_addr(slot_addr),
      .ent_cmd(slot_cmd), .key_addr(in_addr), .key_cmd(in_cmd), .hit(slot_hit)
   );

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      for (int i = 0; i < DEPTH; i++)
         if (slot_hit[i]) hit_idx = IDX_W'(i);
      for (int i = DEPTH - 1; i >= 0; i--)
         if (!slot_used[i]) free_idx = IDX_W'(i);
   end

   assign hit_any   = |slot_hit;
   assign free_any  = ~&slot_used;
   assign hit_done  = hit_any && (slot_st[hit_idx] == SLOT_DONE);
   assign enq       = in_req && !hit_any && free_any;
   assign release_e = in_req && hit_done;

   assign in_rsp_retry  = in_req && !hit_done;
   assign in_rsp_ready  = release_e && (slot_term[hit_idx] == TERM_OK);
   assign in_rsp_tabort = release_e && (slot_term[hit_idx] != TERM_OK);
   assign in_rsp_perr   = release_e && slot_perr[hit_idx];

   dwq_order_fifo #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_order (
      .clk(clk), .rst_n(rst_n), .push(enq), .push_idx(free_idx),
      .pop(tg_end), .head_idx(head_idx), .empty(ord_empty)
   );

   assign tg_valid = !ord_empty;
   assign tg_addr  = slot_addr[head_idx];
   assign tg_cmd   = slot_cmd[head_idx];
   assign tg_data  = slot_data[head_idx];
   assign tg_be    = slot_be[head_idx];
   assign tg_term  = tg_valid && (tg_trdy || tg_tabort || tg_mabort);

   dwq_retry_timer #(.CNT_W(RETRY_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .active(tg_valid), .retry(tg_retry),
      .term(tg_term), .lim_en(retry_lim_en), .expire(discard)
   );

   assign tg_end = tg_term || discard;

   always_comb begin
      if (discard)        end_code = TERM_DISCARD;
      else if (tg_trdy)   end_code = TERM_OK;
      else if (tg_tabort) end_code = TERM_TABORT;
      else                end_code = TERM_MABORT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perr_acc  <= 1'b0;
         serr      <= 1'b0;
         slot_addr <= '0;
         slot_cmd  <= '0;
         slot_data <= '0;
         slot_be   <= '0;
         slot_perr <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            slot_st[i]   <= SLOT_FREE;
            slot_term[i] <= TERM_OK;
         end
      end else begin
         serr <= discard && serr_en;
         if (tg_end)                   perr_acc <= 1'b0;
         else if (tg_valid && tg_perr) perr_acc <= 1'b1;
         for (int i = 0; i < DEPTH; i++) begin
            if (enq && free_idx == IDX_W'(i)) begin
               slot_st[i]   <= SLOT_PEND;
               slot_addr[i] <= in_addr;
               slot_cmd[i]  <= in_cmd;
               slot_data[i] <= in_data;
               slot_be[i]   <= in_be;
            end
            if (tg_end && head_idx == IDX_W'(i)) begin
               slot_st[i]   <= SLOT_DONE;
               slot_term[i] <= end_code;
               slot_perr[i] <= perr_acc || tg_perr;
            end
            if (release_e && hit_idx == IDX_W'(i)) slot_st[i] <= SLOT_FREE;
         end
      end
   end

   a_r11_rsp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      in_req |-> $onehot({in_rsp_retry, in_rsp_ready, in_rsp_tabort}))
      else $error("initiator answer not one-hot");
   a_r11_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_req |-> !(in_rsp_retry || in_rsp_ready || in_rsp_tabort || in_rsp_perr))
      else $error("initiator answer without an attempt");
   a_r4_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tg_valid && !tg_end) |=> (tg_valid && $stable(tg_addr) && $stable(tg_cmd)
                                 && $stable(tg_data) && $stable(tg_be)))
      else $error("far-side request changed before it ended");
   a_r7_serr_after_discard: assert property (@(posedge clk) disable iff (!rst_n)
      serr |-> $past(discard && serr_en))
      else $error("error pulse without a discard");
   a_r5_perr_with_answer: assert property (@(posedge clk) disable iff (!rst_n)
      in_rsp_perr |-> (in_rsp_ready || in_rsp_tabort))
      else $error("parity flag outside a completion answer");
endmodule

// File: tb/dwq_ctrl_tb.sv
`timescale 1ns/1ps
module dwq_ctrl_tb;
   localparam int DEP = 4;
   localparam int RW  = 4;
   localparam int LIM = 1 << RW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic retry_lim_en = 1'b1, serr_en = 1'b0;
   logic in_req = 1'b0;
   logic [31:0] in_addr = '0, in_data = '0;
   logic [3:0]  in_cmd = '0, in_be = '0;
   logic in_rsp_retry, in_rsp_ready, in_rsp_tabort, in_rsp_perr;
   logic tg_valid;
   logic [31:0] tg_addr, tg_data;
   logic [3:0]  tg_cmd, tg_be;
   logic tg_trdy = 1'b0, tg_tabort = 1'b0, tg_mabort = 1'b0, tg_retry = 1'b0, tg_perr = 1'b0;
   logic serr;

   always #2.5 clk = ~clk;

   dwq_ctrl #(.ADDR_W(32), .DATA_W(32), .CMD_W(4), .DEPTH(DEP), .RETRY_W(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .retry_lim_en(retry_lim_en), .serr_en(serr_en),
      .in_req(in_req), .in_addr(in_addr), .in_cmd(in_cmd), .in_data(in_data), .in_be(in_be),
      .in_rsp_retry(in_rsp_retry), .in_rsp_ready(in_rsp_ready), .in_rsp_tabort(in_rsp_tabort),
      .in_rsp_perr(in_rsp_perr), .tg_valid(tg_valid), .tg_addr(tg_addr), .tg_cmd(tg_cmd),
      .tg_data(tg_data), .tg_be(tg_be), .tg_trdy(tg_trdy), .tg_tabort(tg_tabort),
      .tg_mabort(tg_mabort), .tg_retry(tg_retry), .tg_perr(tg_perr), .serr(serr)
   );

   int checks = 0, fails = 0;
   bit finished = 0;

   // reference model, entries kept in bench-chosen slots, issue order by sequence number
   bit          mv [DEP];
   bit          mdone [DEP];
   logic [31:0] maddr [DEP];
   logic [3:0]  mcmd [DEP];
   logic [31:0] mdata [DEP];
   logic [3:0]  mbe [DEP];
   int          mterm [DEP];   // 0 ok, 1 target abort, 2 master abort, 3 discard
   bit          mperr [DEP];
   int          mseq [DEP];
   int          seqc = 0, rc = 0;
   bit          pacc = 0, exp_serr = 0;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: act=%0h exp=%0h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic int head_slot();
      int h = -1;
      for (int m = 0; m < DEP; m++)
         if (mv[m] && !mdone[m] && (h < 0 || mseq[m] < mseq[h])) h = m;
      return h;
   endfunction

   function automatic int find_key(input logic [31:0] a, input logic [3:0] c);
      int k = -1;
      for (int m = 0; m < DEP; m++)
         if (mv[m] && maddr[m] == a && mcmd[m] == c) k = m;
      return k;
   endfunction

   // tr: 0 none, 1 trdy, 2 target abort, 3 master abort, 4 retry
   task automatic step(input bit req, input logic [31:0] a, input logic [3:0] c,
                       input logic [31:0] d, input logic [3:0] b, input int tr,
                       input bit pe, input string tag);
      int  h, k, f;
      bit  er, ey, et, ep, tany, expd;
      @(negedge clk);
      in_req = req; in_addr = a; in_cmd = c; in_data = d; in_be = b;
      tg_trdy = (tr == 1); tg_tabort = (tr == 2); tg_mabort = (tr == 3);
      tg_retry = (tr == 4); tg_perr = pe;
      #1;
      h = head_slot();
      k = find_key(a, c);
      er = 0; ey = 0; et = 0; ep = 0;
      if (req) begin
         if (k >= 0 && mdone[k]) begin
            ey = (mterm[k] == 0); et = !ey; ep = mperr[k];
         end else er = 1;
      end
      chk({"R7 serr ", tag}, 32'(serr), 32'(exp_serr));
      chk({"R1 retry ", tag}, 32'(in_rsp_retry), 32'(er));
      chk({"R5 ready ", tag}, 32'(in_rsp_ready), 32'(ey));
      chk({"R5 tabort ", tag}, 32'(in_rsp_tabort), 32'(et));
      chk({"R5 perr ", tag}, 32'(in_rsp_perr), 32'(ep));
      chk({"R4 tg_valid ", tag}, 32'(tg_valid), 32'(h >= 0));
      if (h >= 0) begin
         chk({"R4 tg_addr ", tag}, tg_addr, maddr[h]);
         chk({"R4 tg_cmd ", tag}, 32'(tg_cmd), 32'(mcmd[h]));
         chk({"R3 tg_data ", tag}, tg_data, mdata[h]);
         chk({"R3 tg_be ", tag}, 32'(tg_be), 32'(mbe[h]));
      end
      // model update for the coming edge
      tany = (h >= 0) && (tr >= 1 && tr <= 3);
      expd = (h >= 0) && (tr == 4) && retry_lim_en && (rc == LIM - 1);
      exp_serr = expd && serr_en;
      if (h >= 0) begin
         if (tany || expd) begin
            mdone[h] = 1;
            mterm[h] = expd ? 3 : tr - 1;
            mperr[h] = pacc || pe;
            pacc = 0; rc = 0;
         end else begin
            pacc = pacc || pe;
            if (tr == 4 && retry_lim_en) rc++;
         end
      end
      if (ey || et) mv[k] = 0;
      else if (req && k < 0) begin
         f = -1;
         for (int m = DEP - 1; m >= 0; m--) if (!mv[m]) f = m;
         if (f >= 0) begin
            mv[f] = 1; mdone[f] = 0; maddr[f] = a; mcmd[f] = c;
            mdata[f] = d; mbe[f] = b; mseq[f] = seqc++;
         end
      end
   endtask

   task automatic idle(input int tr, input string tag);
      step(0, '0, '0, '0, '0, tr, 0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R10 watchdog: act=running exp=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5eed);
      for (int m = 0; m < DEP; m++) mv[m] = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10 tg_valid", 32'(tg_valid), 0);
      chk("R10 serr", 32'(serr), 0);
      chk("R10 rsp", 32'({in_rsp_retry, in_rsp_ready, in_rsp_tabort, in_rsp_perr}), 0);

      // R1 first attempt retried, R3 byte enables ignored on the completing attempt
      step(1, 32'h100, 4'h3, 32'hA5A5_0001, 4'hF, 0, 0, "R1");
      idle(1, "R4");
      step(1, 32'h100, 4'h3, 32'h0, 4'h1, 0, 0, "R3");
      step(1, 32'h100, 4'h3, 32'h1111_2222, 4'h3, 0, 0, "R5");
      idle(1, "R5");
      step(1, 32'h100, 4'h3, 32'h0, 4'h0, 0, 0, "R5");

      // R3 pending match keeps original data
      step(1, 32'h200, 4'hB, 32'hDEAD_0001, 4'hF, 0, 0, "R3");
      step(1, 32'h200, 4'hB, 32'hBEEF_0002, 4'h3, 0, 0, "R3");
      idle(1, "R3");
      step(1, 32'h200, 4'hB, 32'hBEEF_0002, 4'h3, 0, 0, "R3");

      // R2 fill the queue while the far side stalls
      for (int i = 0; i < 5; i++) step(1, 32'h300 + 4 * i, 4'h3, 32'h30 + i, 4'hF, 0, 0, "R2");
      for (int i = 0; i < 4; i++) idle(1, "R2");
      for (int i = 0; i < 5; i++) step(1, 32'h300 + 4 * i, 4'h3, 32'h0, 4'hF, 0, 0, "R2");
      idle(1, "R2");
      step(1, 32'h310, 4'h3, 32'h0, 4'hF, 0, 0, "R2");

      // R5 aborts and parity forwarding
      step(1, 32'h400, 4'h3, 32'h4, 4'hF, 0, 0, "R5");
      step(0, 0, 0, 0, 0, 0, 1, "R5");
      idle(3, "R5");
      step(1, 32'h400, 4'h3, 32'h0, 4'hF, 0, 0, "R5");
      step(1, 32'h404, 4'h3, 32'h5, 4'hF, 0, 0, "R5");
      idle(2, "R5");
      step(1, 32'h404, 4'h3, 32'h0, 4'hF, 0, 0, "R5");

      // R6/R7 discard at the limit with the error enable on, then off
      serr_en = 1'b1;
      step(1, 32'h500, 4'h3, 32'h6, 4'hF, 0, 0, "R6");
      for (int i = 0; i < LIM; i++) idle(4, "R6");
      idle(0, "R7");
      step(1, 32'h500, 4'h3, 32'h0, 4'hF, 0, 0, "R6");
      serr_en = 1'b0;
      step(1, 32'h504, 4'h3, 32'h7, 4'hF, 0, 0, "R7");
      for (int i = 0; i < LIM; i++) idle(4, "R7");
      idle(0, "R7");
      step(1, 32'h504, 4'h3, 32'h0, 4'hF, 0, 0, "R7");

      // R9 counter clears per transfer; idle cycles do not clear it
      step(1, 32'h600, 4'h3, 32'h8, 4'hF, 0, 0, "R9");
      step(1, 32'h604, 4'h3, 32'h9, 4'hF, 0, 0, "R9");
      for (int i = 0; i < LIM - 4; i++) begin idle(4, "R9"); idle(0, "R9"); end
      idle(1, "R9");
      for (int i = 0; i < LIM - 4; i++) idle(4, "R9");
      idle(1, "R9");
      step(1, 32'h600, 4'h3, 32'h0, 4'hF, 0, 0, "R9");
      step(1, 32'h604, 4'h3, 32'h0, 4'hF, 0, 0, "R9");

      // R8 limit disabled
      retry_lim_en = 1'b0;
      step(1, 32'h700, 4'hB, 32'hA, 4'hF, 0, 0, "R8");
      for (int i = 0; i < 3 * LIM; i++) idle(4, "R8");
      idle(1, "R8");
      step(1, 32'h700, 4'hB, 32'h0, 4'hF, 0, 0, "R8");
      retry_lim_en = 1'b1;

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         int r, tr;
         bit rq;
         logic [31:0] a;
         logic [3:0]  c;
         rq = ($urandom % 2) == 0;
         a  = 32'h800 + 4 * ($urandom % 6);
         c  = ($urandom % 2) ? 4'h3 : 4'hB;
         tr = 0;
         if (head_slot() >= 0) begin
            r = $urandom % 20;
            if (r < 5) tr = 1; else if (r == 5) tr = 2; else if (r == 6) tr = 3;
            else if (r < 16) tr = 4;
         end
         if ($urandom % 50 == 0) retry_lim_en = ~retry_lim_en;
         if ($urandom % 20 == 0) serr_en = ~serr_en;
         step(rq, a, c, $urandom, 4'($urandom), tr,
              (head_slot() >= 0) && ($urandom % 10 == 0), "RND");
      end

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule